// File: doc/BRIEF.md
# 32-bit Multicycle Integer Core

A small 32-bit integer processor core that executes a load/store instruction subset one step per clock. A two-bit step counter sequences every instruction. Step 0 is the same for all instructions: it fetches the word at the program counter into the instruction register and advances the program counter by four. The following steps depend on the opcode. Operands are read into two ALU input latches, a result is formed in an ALU output latch, and the result is written back to the register file or to memory.

Instruction fetch and data access share a single memory port. The port has an address, read data, write data and a write strobe. Memory is assumed to answer combinationally, with no wait states. Control transfers (both conditional branches, the direct jump and the register jump) finish in two clocks. Every other instruction takes four. The two linking jumps also take four clocks, because the return address travels through the ALU latches before it reaches register 31. There is no delay slot, no pipelining and no exception handling.

Top module: `mc_core`

## Requirements
- R1: While reset is held, the program counter is 0 and the step counter is 0. The memory port shows address 0 with the write strobe low, and the first fetch after reset reads address 0.
- R2: In step 0 the memory address equals the program counter, the instruction register loads the read data, and the program counter advances by 4. The instruction register stays unchanged in all other steps.
- R3: Register-format instructions (opcode 0x00) write rd in step 3, with the function field selecting the operation. The supported functions are add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26, nor 0x27, signed less-than 0x2A, unsigned less-than 0x2B, shift left 0x00 and logical shift right 0x02. Shifts move rt by the shamt field (bits 10:6).
- R4: Immediate instructions write rt in step 3. They are add 0x08, signed less-than 0x0A and xor 0x0E, which use a sign-extended constant, and and 0x0C and or 0x0D, which use a zero-extended constant. Opcode 0x0F places the constant in the upper half and zeros the lower half.
- R5: Load (0x23) and store (0x2B) form rs + sign-extended constant and present it as the memory address in step 3. A load writes the read data to rt. A store raises the write strobe in that step only and drives rt as the write data.
- R6: Branch-if-equal (0x04) and branch-if-not-equal (0x05) compare rs with rt. When taken, they set PC to (instruction address + 4) + sign-extended constant × 4; otherwise execution continues at the next word. Both forward and backward offsets work.
- R7: The direct jump (0x02) sets PC to {PC[31:28], target field, 2'b00}. The register jump (opcode 0x00, function 0x08) sets PC to rs. Neither writes a register.
- R8: The linking direct jump (0x03) and the linking register jump (opcode 0x00, function 0x09) jump as in R7. They write the jump's own address + 4 to register 31 in step 3, which makes them four-clock instructions.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: The step counter returns to 0 after step 1 for the two branches, the direct jump and the register jump. For every other instruction it returns to 0 after step 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe, stores mem_wdata at mem_addr on the clock edge |

## Verification
Two events share a single clock in the linking jumps. In step 1 the program counter is overwritten with the jump target while its old, already-incremented value is captured in the ALU input latch as the return address. The bench provokes this with a linking direct jump and a linking register jump, each followed at its target by a store of register 31. It then judges the result by the stored link value and by the fact that the target was reached. The load path shows the same overlap: in step 3 the shared port carries a data address while the read data goes to write-back. Sweeps that load operands and store results confirm that the two uses of the port never collide.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN = 32;

    // primary opcodes (bits 31:26)
    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_J    = 6'h02;
    localparam logic [5:0] OP_JL   = 6'h03;
    localparam logic [5:0] OP_BEQ  = 6'h04;
    localparam logic [5:0] OP_BNE  = 6'h05;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_SLTI = 6'h0A;
    localparam logic [5:0] OP_ANDI = 6'h0C;
    localparam logic [5:0] OP_ORI  = 6'h0D;
    localparam logic [5:0] OP_XORI = 6'h0E;
    localparam logic [5:0] OP_LUI  = 6'h0F;
    localparam logic [5:0] OP_LD   = 6'h23;
    localparam logic [5:0] OP_ST   = 6'h2B;

    // function codes (bits 5:0) for OP_REG
    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_JR   = 6'h08;
    localparam logic [5:0] FN_JLR  = 6'h09;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_UPPER, ALU_PASS
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] res;
        logic [1:0]      step;
    } core_s;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [4:0]     shamt,
    output logic [W-1:0]   y
);
    localparam int HALF = W / 2;

    always_comb begin
        unique case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_NOR:   y = ~(a | b);
            ALU_SLT:   y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            ALU_SLTU:  y = (a < b) ? W'(1) : '0;
            ALU_SLL:   y = b << shamt;
            ALU_SRL:   y = b >> shamt;
            ALU_UPPER: y = b << HALF;
            default:   y = a;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W = 32,
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] raddr_a,
    input  logic [$clog2(N)-1:0] raddr_b,
    output logic [W-1:0]         rdata_a,
    output logic [W-1:0]         rdata_b
);
    localparam int AW = $clog2(N);

    logic [W-1:0] regs_q [N];

    // entry 0 is never written; reads of it return zero
    always_ff @(posedge clk) begin
        if (we && (waddr != AW'(0))) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == AW'(0)) ? '0 : regs_q[raddr_a];
    assign rdata_b = (raddr_b == AW'(0)) ? '0 : regs_q[raddr_b];
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter int          NREGS    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_wdata,
    output logic        mem_we
);
    localparam int RAW = $clog2(NREGS);
    localparam logic [RAW-1:0] LINK_REG = RAW'(NREGS - 1);
    localparam logic [1:0] ST_FETCH = 2'd0;
    localparam logic [1:0] ST_READ  = 2'd1;
    localparam logic [1:0] ST_EXEC  = 2'd2;
    localparam logic [1:0] ST_WRITE = 2'd3;

    core_s s_q, s_d;

    // instruction fields
    logic [5:0]  opc, fn;
    logic [4:0]  f_rs, f_rt, f_rd, f_sh;
    logic [15:0] f_imm;
    logic [31:0] imm_sx, imm_zx, imm_ext;
    assign opc   = s_q.ir[31:26];
    assign f_rs  = s_q.ir[25:21];
    assign f_rt  = s_q.ir[20:16];
    assign f_rd  = s_q.ir[15:11];
    assign f_sh  = s_q.ir[10:6];
    assign fn    = s_q.ir[5:0];
    assign f_imm = s_q.ir[15:0];
    assign imm_sx = {{16{f_imm[15]}}, f_imm};
    assign imm_zx = {16'h0000, f_imm};

    // instruction classes
    logic is_reg, is_jr, is_jlr, is_imm, is_ld, is_st, is_br, is_j, is_jl;
    logic quick_op, writes_back, br_taken;
    assign is_jr   = (opc == OP_REG) && (fn == FN_JR);
    assign is_jlr  = (opc == OP_REG) && (fn == FN_JLR);
    assign is_reg  = (opc == OP_REG) && !is_jr && !is_jlr;
    assign is_imm  = (opc == OP_ADDI) || (opc == OP_SLTI) || (opc == OP_ANDI) ||
                     (opc == OP_ORI)  || (opc == OP_XORI) || (opc == OP_LUI);
    assign is_ld   = (opc == OP_LD);
    assign is_st   = (opc == OP_ST);
    assign is_br   = (opc == OP_BEQ) || (opc == OP_BNE);
    assign is_j    = (opc == OP_J);
    assign is_jl   = (opc == OP_JL);
    assign quick_op    = is_br || is_j || is_jr;
    assign writes_back = is_reg || is_imm || is_ld || is_jl || is_jlr;
    assign imm_ext = ((opc == OP_ANDI) || (opc == OP_ORI) || (opc == OP_LUI)) ? imm_zx : imm_sx;

    // register file
    logic [31:0]    rf_a, rf_b, rf_wdata;
    logic [RAW-1:0] rf_waddr;
    logic           rf_we;
    assign br_taken = (opc == OP_BEQ) ? (rf_a == rf_b) : (rf_a != rf_b);

    mc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (RAW'(f_rs)),
        .raddr_b (RAW'(f_rt)),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    // ALU operation select
    alu_op_e alu_op;
    logic [31:0] alu_y;
    always_comb begin
        alu_op = ALU_ADD;
        if (is_reg) begin
            case (fn)
                FN_SUB:  alu_op = ALU_SUB;
                FN_AND:  alu_op = ALU_AND;
                FN_OR:   alu_op = ALU_OR;
                FN_XOR:  alu_op = ALU_XOR;
                FN_NOR:  alu_op = ALU_NOR;
                FN_SLT:  alu_op = ALU_SLT;
                FN_SLTU: alu_op = ALU_SLTU;
                FN_SLL:  alu_op = ALU_SLL;
                FN_SRL:  alu_op = ALU_SRL;
                default: alu_op = ALU_ADD;
            endcase
        end else if (is_imm) begin
            case (opc)
                OP_SLTI: alu_op = ALU_SLT;
                OP_ANDI: alu_op = ALU_AND;
                OP_ORI:  alu_op = ALU_OR;
                OP_XORI: alu_op = ALU_XOR;
                OP_LUI:  alu_op = ALU_UPPER;
                default: alu_op = ALU_ADD;
            endcase
        end else if (is_jl || is_jlr) begin
            alu_op = ALU_PASS;
        end
    end

    mc_alu #(.W(XLEN)) u_alu (
        .op    (alu_op),
        .a     (s_q.opa),
        .b     (s_q.opb),
        .shamt (f_sh),
        .y     (alu_y)
    );

    // next-state logic
    always_comb begin
        s_d = s_q;
        unique case (s_q.step)
            ST_FETCH: begin
                s_d.ir   = mem_rdata;
                s_d.pc   = s_q.pc + 32'd4;
                s_d.step = ST_READ;
            end
            ST_READ: begin
                s_d.opa  = (is_jl || is_jlr) ? s_q.pc : rf_a;
                s_d.opb  = is_imm ? imm_ext : ((is_ld || is_st) ? imm_sx : rf_b);
                if (is_br && br_taken) s_d.pc = s_q.pc + {imm_sx[29:0], 2'b00};
                if (is_j || is_jl)     s_d.pc = {s_q.pc[31:28], s_q.ir[25:0], 2'b00};
                if (is_jr || is_jlr)   s_d.pc = rf_a;
                s_d.step = quick_op ? ST_FETCH : ST_EXEC;
            end
            ST_EXEC: begin
                s_d.res  = alu_y;
                s_d.step = ST_WRITE;
            end
            default: begin
                s_d.step = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.pc <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end

    // write-back and memory port
    always_comb begin
        rf_we    = (s_q.step == ST_WRITE) && writes_back;
        rf_waddr = is_reg ? RAW'(f_rd) : ((is_jl || is_jlr) ? LINK_REG : RAW'(f_rt));
        rf_wdata = is_ld ? mem_rdata : s_q.res;
    end

    assign mem_addr  = ((s_q.step == ST_WRITE) && (is_ld || is_st)) ? s_q.res : s_q.pc;
    assign mem_we    = (s_q.step == ST_WRITE) && is_st;
    assign mem_wdata = rf_b;

    // R2
    fetch_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_FETCH) |=> (s_q.pc == $past(s_q.pc) + 32'd4));

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step != ST_FETCH) |=> $stable(s_q.ir));

    // R10
    long_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_WRITE) |=> (s_q.step == ST_FETCH));

    // R10
    quick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_READ && quick_op) |=> (s_q.step == ST_FETCH));

    // R10
    long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_READ && !quick_op) |=> (s_q.step == ST_EXEC));

    // R7
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step == ST_EXEC || s_q.step == ST_WRITE) |=> $stable(s_q.pc));

    // R5
    store_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we && mem_addr == s_q.pc));
endmodule

// File: tb/mc_core_tb.sv
module mc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_we;
    logic [31:0] mem [0:255];
    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    mc_core u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

    function automatic logic [31:0] enc_r(logic [5:0] f, logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [4:0] sh);
        return {6'h00, rs, rt, rd, sh, f};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                          logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] tgt);
        return {op, tgt};
    endfunction

    function automatic logic [31:0] ref_r(logic [5:0] f, logic [31:0] a, logic [31:0] b,
                                          logic [4:0] sh);
        case (f)
            6'h20: return a + b;
            6'h22: return a - b;
            6'h24: return a & b;
            6'h25: return a | b;
            6'h26: return a ^ b;
            6'h27: return ~(a | b);
            6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6'h2B: return (a < b) ? 32'd1 : 32'd0;
            6'h00: return b << sh;
            default: return b >> sh;
        endcase
    endfunction
    function automatic logic [31:0] ref_i(logic [5:0] op, logic [31:0] a, logic [15:0] imm);
        logic [31:0] se, ze;
        se = {{16{imm[15]}}, imm};
        ze = {16'h0, imm};
        case (op)
            6'h08: return a + se;
            6'h0A: return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
            6'h0C: return a & ze;
            6'h0D: return a | ze;
            6'h0E: return a ^ se;
            default: return {imm, 16'h0};
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic prep();
        rst_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    endtask

    task automatic go(int n);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] vals [6];
    logic [5:0]  rfn  [10];
    logic [5:0]  iop  [6];
    logic [15:0] imms [5];

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        vals = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
        rfn  = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B, 6'h00, 6'h02};
        iop  = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h0F};
        imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

        // R1 / R2 / R5 / R7 / R10: port timing around reset, a jump and a store
        prep();
        mem[0] = enc_j(6'h02, 26'd4);
        mem[4] = enc_i(6'h2B, 5'd0, 5'd0, 16'h0080);
        mem[5] = enc_j(6'h02, 26'd5);
        chk("R1 addr in reset", mem_addr, 32'h0);
        chk("R1 we in reset", {31'h0, mem_we}, 32'h0);
        go(2);
        chk("R7 R10 jump done in 2 cycles", mem_addr, 32'h10);
        repeat (3) @(negedge clk);
        chk("R5 store address in step 3", mem_addr, 32'h80);
        chk("R5 store strobe in step 3", {31'h0, mem_we}, 32'h1);
        chk("R5 store data", mem_wdata, 32'h0);
        @(negedge clk);
        chk("R2 next fetch at pc+4", mem_addr, 32'h14);
        chk("R5 strobe drops", {31'h0, mem_we}, 32'h0);

        // R8 / R10: linking jump takes 4 cycles, then store r31
        prep();
        mem[0] = enc_j(6'h03, 26'd4);
        mem[4] = enc_i(6'h2B, 5'd0, 5'd31, 16'h0080);
        mem[5] = enc_j(6'h02, 26'd5);
        go(6);
        chk("R8 R10 no store before cycle 7", {31'h0, mem_we}, 32'h0);
        @(negedge clk);
        chk("R8 R10 store in cycle 7", {31'h0, mem_we}, 32'h1);
        chk("R8 link value", mem_wdata, 32'h4);

        // R3: register-format sweep
        foreach (rfn[f]) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [4:0] sh;
                    sh = 5'((i * 7 + j * 5) % 32);
                    prep();
                    mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
                    mem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
                    mem[2] = enc_r(rfn[f], 5'd1, 5'd2, 5'd3, sh);
                    mem[3] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
                    mem[4] = enc_j(6'h02, 26'd4);
                    mem[64] = vals[i];
                    mem[65] = vals[j];
                    go(20);
                    chk($sformatf("R3 fn=%h", rfn[f]), mem[66], ref_r(rfn[f], vals[i], vals[j], sh));
                end
            end
        end

        // R4: immediate sweep
        foreach (iop[o]) begin
            for (int i = 0; i < 6; i++) begin
                for (int m = 0; m < 5; m++) begin
                    prep();
                    mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
                    mem[1] = enc_i(iop[o], 5'd1, 5'd3, imms[m]);
                    mem[2] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
                    mem[3] = enc_j(6'h02, 26'd3);
                    mem[64] = vals[i];
                    go(16);
                    chk($sformatf("R4 op=%h", iop[o]), mem[66], ref_i(iop[o], vals[i], imms[m]));
                end
            end
        end

        // R5: negative offsets on load and store
        for (int i = 0; i < 6; i++) begin
            prep();
            mem[0] = enc_i(6'h0D, 5'd0, 5'd1, 16'h0110);
            mem[1] = enc_i(6'h23, 5'd1, 5'd2, 16'hFFF4);
            mem[2] = enc_i(6'h2B, 5'd1, 5'd2, 16'hFFF8);
            mem[3] = enc_j(6'h02, 26'd3);
            mem[65] = vals[i];
            go(16);
            chk("R5 load/store negative offset", mem[66], vals[i]);
        end

        // R6: forward branches over all operand pairs
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic taken;
                    taken = (b == 0) ? (vals[i] == vals[j]) : (vals[i] != vals[j]);
                    prep();
                    mem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
                    mem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
                    mem[2] = enc_i(6'h0D, 5'd0, 5'd3, 16'h0000);
                    mem[3] = enc_i((b == 0) ? 6'h04 : 6'h05, 5'd1, 5'd2, 16'h0001);
                    mem[4] = enc_i(6'h0D, 5'd0, 5'd3, 16'h0011);
                    mem[5] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
                    mem[6] = enc_j(6'h02, 26'd6);
                    mem[64] = vals[i];
                    mem[65] = vals[j];
                    go(28);
                    chk($sformatf("R6 branch kind=%0d", b), mem[66], taken ? 32'h0 : 32'h11);
                end
            end
        end

        // R6: backward branch loop, two passes of +5
        prep();
        mem[0] = enc_i(6'h0D, 5'd0, 5'd1, 16'h0002);
        mem[1] = enc_i(6'h0D, 5'd0, 5'd2, 16'h0000);
        mem[2] = enc_i(6'h08, 5'd1, 5'd1, 16'hFFFF);
        mem[3] = enc_i(6'h08, 5'd2, 5'd2, 16'h0005);
        mem[4] = enc_i(6'h05, 5'd1, 5'd0, 16'hFFFD);
        mem[5] = enc_i(6'h2B, 5'd0, 5'd2, 16'h0108);
        mem[6] = enc_j(6'h02, 26'd6);
        go(50);
        chk("R6 backward loop", mem[66], 32'd10);

        // R7: register jump skips the following word
        prep();
        mem[0]  = enc_i(6'h0D, 5'd0, 5'd6, 16'h0050);
        mem[1]  = enc_r(6'h08, 5'd6, 5'd0, 5'd0, 5'd0);
        mem[2]  = enc_i(6'h0D, 5'd0, 5'd6, 16'h0099);
        mem[20] = enc_i(6'h2B, 5'd0, 5'd6, 16'h0108);
        mem[21] = enc_j(6'h02, 26'd21);
        go(24);
        chk("R7 register jump", mem[66], 32'h50);

        // R8: both linking jumps and their return addresses
        prep();
        mem[0]  = enc_i(6'h0D, 5'd0, 5'd5, 16'h0040);
        mem[1]  = enc_j(6'h03, 26'd8);
        mem[8]  = enc_i(6'h2B, 5'd0, 5'd31, 16'h0108);
        mem[9]  = enc_r(6'h09, 5'd5, 5'd0, 5'd31, 5'd0);
        mem[16] = enc_i(6'h2B, 5'd0, 5'd31, 16'h010C);
        mem[17] = enc_j(6'h02, 26'd17);
        go(36);
        chk("R8 direct link", mem[66], 32'h8);
        chk("R8 register link", mem[67], 32'h28);

        // R9: writes to register 0 are discarded
        prep();
        mem[0]  = enc_i(6'h0D, 5'd0, 5'd0, 16'h0055);
        mem[1]  = enc_i(6'h23, 5'd0, 5'd0, 16'h0100);
        mem[2]  = enc_r(6'h20, 5'd0, 5'd0, 5'd0, 5'd0);
        mem[3]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0108);
        mem[4]  = enc_i(6'h08, 5'd0, 5'd3, 16'h0007);
        mem[5]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h010C);
        mem[6]  = enc_j(6'h02, 26'd6);
        mem[64] = 32'hCAFE_F00D;
        mem[66] = 32'hDEAD_BEEF;
        go(32);
        chk("R9 r0 stays zero", mem[66], 32'h0);
        chk("R9 r0 source is zero", mem[67], 32'h7);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule